// File: doc/BRIEF.md
# Vector Loop Predicate Generator

This block produces the governing predicate for a vector "while below" loop step. It takes two scalar bounds and works out how many vector elements the loop still covers. It then sets the predicate bit that starts each of those elements, and the first element is always the lowest one. The operands can be treated as 32-bit or 64-bit values. The comparison can be signed or unsigned and strict or inclusive. Elements can be 1, 2, 4 or 8 bytes wide. The vector length is a build-time parameter.

A request is accepted whenever `req_valid` is high, one per cycle. The predicate and four condition flags come back from registers on the next clock edge, marked by `rsp_valid`. The element count is formed as a difference and then clamped to the vector capacity. The one case where the inclusive increment could wrap is caught and turned into an all-active predicate.

Top module: `vec_while_pred`

## Requirements
- R1: `rsp_valid` is high in the cycle after each cycle in which `req_valid` is high, and low otherwise; the predicate and flags for a request appear together with that `rsp_valid`.
- R2: With `wide` = 0, only bits 31:0 of each operand count. They are zero-extended when `is_unsigned` = 1 and sign-extended when `is_unsigned` = 0, and bits 63:32 have no effect on the result.
- R3: In the strict form (`incl` = 0), if `op_a` is below `op_b`, the active element count is `op_b - op_a` before clamping.
- R4: In the inclusive form (`incl` = 1), if `op_a` is at or below `op_b`, the count is `op_b - op_a + 1` before clamping.
- R5: In the inclusive form, if `op_b` equals the largest value of the selected width and signedness, every element is active. The four largest values are 0xFFFFFFFF, 0x7FFFFFFF, 2^64-1 and 2^63-1.
- R6: If the comparison fails (`op_a` not below `op_b`, or not at or below it in the inclusive form), no predicate bit is set. The comparison is signed or unsigned as selected.
- R7: The count is clamped to the capacity, which is VL_BITS/8 >> `esz` elements.
- R8: `esz` codes 0, 1, 2 and 3 give 1, 2, 4 and 8 bytes per element. Element k, counted from 0, owns predicate bit k·2^esz. Only the owning bits of active elements are set.
- R9: `rsp_n` is high when element 0 is active. `rsp_z` is high when no element is active. `rsp_c` is high when the last element is inactive. `rsp_v` is always low.
- R10: While reset is asserted, `rsp_valid`, `rsp_pred` and all flags are zero.
- R11: In a cycle with no request, the predicate and flags keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| op_a | input | 64 | Starting (lower) operand |
| op_b | input | 64 | Bound (upper) operand |
| wide | input | 1 | 1: 64-bit operands, 0: 32-bit operands |
| is_unsigned | input | 1 | 1: unsigned compare, 0: signed compare |
| incl | input | 1 | 1: at-or-below form, 0: strictly-below form |
| esz | input | 2 | Element size code (bytes = 2^esz) |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_pred | output | VL_BITS/8 | Predicate, one bit per vector byte |
| rsp_n | output | 1 | First element active |
| rsp_z | output | 1 | No element active |
| rsp_c | output | 1 | Last element inactive |
| rsp_v | output | 1 | Always zero |

## Verification
Every result is due exactly one rising edge after the request that caused it. The bench drives a request on a falling edge and drops it on the next falling edge. It reads `rsp_valid`, the predicate and the flags at that same falling edge, which lies halfway between the capturing edge and the following one. One falling edge later, it confirms that `rsp_valid` has dropped and the predicate is unchanged. The expected predicate comes from a loop that steps the first operand by one, wraps it in the selected width, and stops at the first failed comparison.

// File: rtl/wp_pkg.sv
`timescale 1ns/1ps
package wp_pkg;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } wp_flags_t;

   // widen an operand according to width and signedness
   function automatic logic [63:0] wp_extend(input logic [63:0] x,
                                             input logic        wide,
                                             input logic        uns);
      if (wide)     return x;
      else if (uns) return {32'h0, x[31:0]};
      else          return {{32{x[31]}}, x[31:0]};
   endfunction

   // largest representable value, already widened to 64 bits
   function automatic logic [63:0] wp_top_value(input logic wide,
                                                input logic uns);
      case ({wide, uns})
         2'b00:   return 64'h0000_0000_7FFF_FFFF;
         2'b01:   return 64'h0000_0000_FFFF_FFFF;
         2'b10:   return 64'h7FFF_FFFF_FFFF_FFFF;
         default: return 64'hFFFF_FFFF_FFFF_FFFF;
      endcase
   endfunction

endpackage

// File: rtl/wp_extend.sv
`timescale 1ns/1ps
module wp_extend_pair (
   input  logic [63:0] raw_a,
   input  logic [63:0] raw_b,
   input  logic        wide,
   input  logic        uns,
   output logic [63:0] ext_a,
   output logic [63:0] ext_b
);
   import wp_pkg::*;

   always_comb begin
      ext_a = wp_extend(raw_a, wide, uns);
      ext_b = wp_extend(raw_b, wide, uns);
   end
endmodule

// File: rtl/wp_count.sv
`timescale 1ns/1ps
module wp_count #(
   parameter int VL_BYTES = 32,
   parameter int CNT_W    = 6
) (
   input  logic [63:0]      ext_a,
   input  logic [63:0]      ext_b,
   input  logic             wide,
   input  logic             uns,
   input  logic             incl,
   input  logic [1:0]       esz,
   output logic [CNT_W-1:0] nbits
);
   import wp_pkg::*;

   localparam logic [CNT_W-1:0] FULL = CNT_W'(VL_BYTES);

   logic [CNT_W-1:0] cap;
   logic [63:0]      cap64;
   logic [63:0]      diff;
   logic [63:0]      span;
   logic             cond;
   logic [CNT_W-1:0] elems;

   always_comb begin
      cap   = FULL >> esz;
      cap64 = 64'(cap);
      diff  = ext_b - ext_a;
      span  = incl ? diff + 64'd1 : diff;
      // the only wrapping case: inclusive bound at the top value
      if (incl && (ext_b == wp_top_value(wide, uns)))
         span = cap64;

      if (uns) cond = incl ? (ext_a <= ext_b) : (ext_a < ext_b);
      else     cond = incl ? ($signed(ext_a) <= $signed(ext_b))
                           : ($signed(ext_a) <  $signed(ext_b));

      elems = (span < cap64) ? span[CNT_W-1:0] : cap;
      if (!cond) elems = '0;
      nbits = elems << esz;
   end
endmodule

// File: rtl/wp_mask.sv
`timescale 1ns/1ps
module wp_mask #(
   parameter int PRED_W = 32,
   parameter int CNT_W  = 6
) (
   input  logic [CNT_W-1:0]  nbits,
   input  logic [1:0]        esz,
   output logic [PRED_W-1:0] pred,
   output wp_pkg::wp_flags_t flags
);
   logic [2:0] low_mask;
   assign low_mask = (3'd1 << esz) - 3'd1;

   for (genvar i = 0; i < PRED_W; i++) begin : g_bit
      localparam logic [CNT_W-1:0] POS = CNT_W'(i);
      localparam logic [2:0]       LOW = 3'(i % 8);
      assign pred[i] = (POS < nbits) && ((LOW & low_mask) == 3'd0);
   end

   logic last_on;
   always_comb begin
      case (esz)
         2'd0:    last_on = pred[PRED_W-1];
         2'd1:    last_on = pred[PRED_W-2];
         2'd2:    last_on = pred[PRED_W-4];
         default: last_on = pred[PRED_W-8];
      endcase
      flags.n = pred[0];
      flags.z = ~|pred;
      flags.c = ~last_on;
      flags.v = 1'b0;
   end
endmodule

// File: rtl/vec_while_pred.sv
`timescale 1ns/1ps
module vec_while_pred #(
   parameter int VL_BITS = 256
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [63:0]          op_a,
   input  logic [63:0]          op_b,
   input  logic                 wide,
   input  logic                 is_unsigned,
   input  logic                 incl,
   input  logic [1:0]           esz,
   output logic                 rsp_valid,
   output logic [VL_BITS/8-1:0] rsp_pred,
   output logic                 rsp_n,
   output logic                 rsp_z,
   output logic                 rsp_c,
   output logic                 rsp_v
);
   import wp_pkg::*;

   localparam int VL_BYTES = VL_BITS / 8;
   localparam int PRED_W   = VL_BYTES;
   localparam int CNT_W    = $clog2(VL_BYTES) + 1;

   if ((VL_BITS % 128) != 0 || VL_BITS < 128 || VL_BITS > 2048) begin : g_bad_vl
      $error("vec_while_pred: VL_BITS must be a multiple of 128 in 128..2048");
   end

   logic [63:0]       ext_a, ext_b;
   logic [CNT_W-1:0]  nbits;
   logic [PRED_W-1:0] pred_d, pred_q;
   wp_flags_t         flags_d, flags_q;
   logic              valid_q;

   wp_extend_pair u_ext (
      .raw_a (op_a),
      .raw_b (op_b),
      .wide  (wide),
      .uns   (is_unsigned),
      .ext_a (ext_a),
      .ext_b (ext_b)
   );

   wp_count #(.VL_BYTES(VL_BYTES), .CNT_W(CNT_W)) u_cnt (
      .ext_a (ext_a),
      .ext_b (ext_b),
      .wide  (wide),
      .uns   (is_unsigned),
      .incl  (incl),
      .esz   (esz),
      .nbits (nbits)
   );

   wp_mask #(.PRED_W(PRED_W), .CNT_W(CNT_W)) u_mask (
      .nbits (nbits),
      .esz   (esz),
      .pred  (pred_d),
      .flags (flags_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         pred_q  <= '0;
         flags_q <= '0;
      end else begin
         valid_q <= req_valid;
         if (req_valid) begin
            pred_q  <= pred_d;
            flags_q <= flags_d;
         end
      end
   end

   assign rsp_valid = valid_q;
   assign rsp_pred  = pred_q;
   assign rsp_n     = flags_q.n;
   assign rsp_z     = flags_q.z;
   assign rsp_c     = flags_q.c;
   assign rsp_v     = flags_q.v;
endmodule

// File: rtl/wp_chk.sv
`timescale 1ns/1ps
module wp_chk #(
   parameter int VL_BITS = 256
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic [63:0]          op_a,
   input logic [63:0]          op_b,
   input logic                 wide,
   input logic                 is_unsigned,
   input logic                 incl,
   input logic [1:0]           esz,
   input logic                 rsp_valid,
   input logic [VL_BITS/8-1:0] rsp_pred,
   input logic                 rsp_n,
   input logic                 rsp_z,
   input logic                 rsp_c,
   input logic                 rsp_v
);
   localparam int PW = VL_BITS / 8;

   function automatic logic [63:0] ext(input logic [63:0] x, input logic w, input logic u);
      if (w)      return x;
      else if (u) return {32'h0, x[31:0]};
      else        return {{32{x[31]}}, x[31:0]};
   endfunction

   function automatic logic [PW-1:0] align_bits(input logic [1:0] e);
      logic [PW-1:0] m;
      for (int i = 0; i < PW; i++) m[i] = ((i % (1 << e)) == 0);
      return m;
   endfunction

   logic [63:0] xa, xb, top;
   logic        pass_cmp;
   always_comb begin
      xa  = ext(op_a, wide, is_unsigned);
      xb  = ext(op_b, wide, is_unsigned);
      top = wide ? (is_unsigned ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h7FFF_FFFF_FFFF_FFFF)
                 : (is_unsigned ? 64'h0000_0000_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF);
      if (is_unsigned) pass_cmp = incl ? (xa <= xb) : (xa < xb);
      else             pass_cmp = incl ? ($signed(xa) <= $signed(xb)) : ($signed(xa) < $signed(xb));
   end

   logic          full_q, empty_q;
   logic [PW-1:0] align_q;
   int unsigned   cap_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q  <= 1'b0;
         empty_q <= 1'b0;
         align_q <= '1;
         cap_q   <= PW;
      end else if (req_valid) begin
         full_q  <= incl && (xb == top);
         empty_q <= !pass_cmp;
         align_q <= align_bits(esz);
         cap_q   <= PW >> esz;
      end
   end

   // R1
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   // R1
   valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R5
   incl_top_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && full_q |-> $countones(rsp_pred) == cap_q);
   // R6
   cmp_fail_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && empty_q |-> rsp_pred == '0);
   // R7
   cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $countones(rsp_pred) <= cap_q);
   // R8
   align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_pred & ~align_q) == '0);
   // R9
   flag_nv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_n == rsp_pred[0]) && !rsp_v);
   // R9
   flag_zc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_pred == '0 |-> rsp_z && rsp_c);
   // R11
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(rsp_pred) && $stable(rsp_z));
endmodule

bind vec_while_pred wp_chk #(.VL_BITS(VL_BITS)) u_wp_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .op_a        (op_a),
   .op_b        (op_b),
   .wide        (wide),
   .is_unsigned (is_unsigned),
   .incl        (incl),
   .esz         (esz),
   .rsp_valid   (rsp_valid),
   .rsp_pred    (rsp_pred),
   .rsp_n       (rsp_n),
   .rsp_z       (rsp_z),
   .rsp_c       (rsp_c),
   .rsp_v       (rsp_v)
);

// File: tb/vec_while_pred_tb.sv
`timescale 1ns/1ps
module vec_while_pred_tb;
   localparam int VL_BITS = 256;
   localparam int PW      = VL_BITS / 8;

   typedef struct packed {
      logic [63:0] a;
      logic [63:0] b;
      logic        wide;
      logic        uns;
      logic        incl;
      logic [1:0]  esz;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VEC [NV] = '{
      '{64'd0, 64'd5, 1'b1, 1'b1, 1'b0, 2'd0},                 // R3 five bytes
      '{64'd0, 64'd5, 1'b1, 1'b1, 1'b1, 2'd0},                 // R4 six bytes
      '{64'd3, 64'd3, 1'b1, 1'b1, 1'b0, 2'd0},                 // R6 equal, strict
      '{64'd3, 64'd3, 1'b1, 1'b1, 1'b1, 2'd2},                 // R4 equal, inclusive
      '{64'd0, 64'd100, 1'b1, 1'b1, 1'b0, 2'd0},               // R7 clamp bytes
      '{64'd0, 64'd100, 1'b1, 1'b1, 1'b0, 2'd3},               // R7 clamp dwords
      '{-64'sd3, 64'd2, 1'b1, 1'b0, 1'b0, 2'd1},               // R3 signed span
      '{-64'sd3, 64'd2, 1'b1, 1'b1, 1'b0, 2'd1},               // R6 unsigned fails
      '{64'h1234_5678_FFFF_FFFE, 64'hABCD_0000_0000_0001, 1'b0, 1'b0, 1'b0, 2'd0}, // R2 signed 32
      '{64'h1234_5678_FFFF_FFFE, 64'hABCD_0000_0000_0001, 1'b0, 1'b1, 1'b0, 2'd0}, // R2 unsigned 32
      '{64'hFFFF_FFFF_FFFF_FFF0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b1, 2'd0}, // R5 64u
      '{64'd0, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b1, 2'd1},                 // R5 64s
      '{64'h0000_0000_FFFF_FFF0, 64'h5555_0000_FFFF_FFFF, 1'b0, 1'b1, 1'b1, 2'd0}, // R5 32u
      '{64'hFFFF_FFFF_FFFF_FFFB, 64'h0000_0000_7FFF_FFFF, 1'b0, 1'b0, 1'b1, 2'd2}, // R5 32s
      '{64'hFFFF_FFFF_FFFF_FFFC, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b0, 2'd0}, // R3 strict at top
      '{64'd0, 64'd0, 1'b1, 1'b1, 1'b1, 2'd3},                 // R9 one of four, C set
      '{64'd0, 64'd8, 1'b1, 1'b1, 1'b0, 2'd2}                  // R9 exactly full, C clear
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [63:0]   op_a = '0, op_b = '0;
   logic          wide = 1'b0, is_unsigned = 1'b0, incl = 1'b0;
   logic [1:0]    esz = '0;
   logic          rsp_valid, rsp_n, rsp_z, rsp_c, rsp_v;
   logic [PW-1:0] rsp_pred;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   vec_while_pred #(.VL_BITS(VL_BITS)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op_a(op_a), .op_b(op_b),
      .wide(wide), .is_unsigned(is_unsigned), .incl(incl), .esz(esz),
      .rsp_valid(rsp_valid), .rsp_pred(rsp_pred), .rsp_n(rsp_n), .rsp_z(rsp_z),
      .rsp_c(rsp_c), .rsp_v(rsp_v)
   );

   function automatic logic [63:0] ext(input logic [63:0] x, input logic w, input logic u);
      if (w)      return x;
      else if (u) return {32'h0, x[31:0]};
      else        return {{32{x[31]}}, x[31:0]};
   endfunction

   // increment-and-compare loop, wrapping in the operand width
   function automatic logic [PW-1:0] model(input vec_t v);
      logic [PW-1:0] p = '0;
      logic [63:0]   cur = v.a;
      logic          run = 1'b1;
      logic          ok;
      logic [63:0]   ea, eb;
      int            cap = PW >> v.esz;
      for (int e = 0; e < cap; e++) begin
         ea = ext(cur, v.wide, v.uns);
         eb = ext(v.b, v.wide, v.uns);
         if (v.uns) ok = v.incl ? (ea <= eb) : (ea < eb);
         else       ok = v.incl ? ($signed(ea) <= $signed(eb)) : ($signed(ea) < $signed(eb));
         run = run && ok;
         if (run) p[e << v.esz] = 1'b1;
         cur = cur + 64'd1;
      end
      return p;
   endfunction

   task automatic check(input logic ok, input string what, input logic [PW-1:0] act,
                        input logic [PW-1:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      @(negedge clk);
      op_a = v.a; op_b = v.b; wide = v.wide; is_unsigned = v.uns;
      incl = v.incl; esz = v.esz; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic run_vec(input vec_t v, input int idx);
      logic [PW-1:0] exp_p;
      logic [3:0]    exp_f, act_f;
      int            lastb;
      exp_p = model(v);
      lastb = PW - (1 << v.esz);
      exp_f = {exp_p[0], exp_p == '0, !exp_p[lastb], 1'b0};
      apply(v);
      act_f = {rsp_n, rsp_z, rsp_c, rsp_v};
      check(rsp_valid == 1'b1, $sformatf("R1 valid vec %0d", idx), PW'(rsp_valid), PW'(1));
      check(rsp_pred == exp_p, $sformatf("R8 pred vec %0d", idx), rsp_pred, exp_p);
      check(act_f == exp_f, $sformatf("R9 flags vec %0d", idx), PW'(act_f), PW'(exp_f));
   endtask

   initial begin
      #800000;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [PW-1:0] held;
      repeat (3) @(negedge clk);
      // R10 reset state
      check(rsp_valid == 1'b0, "R10 valid in reset", PW'(rsp_valid), '0);
      check(rsp_pred == '0, "R10 pred in reset", rsp_pred, '0);
      check({rsp_n, rsp_z, rsp_c, rsp_v} == 4'b0, "R10 flags in reset",
            PW'({rsp_n, rsp_z, rsp_c, rsp_v}), '0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

      // R1 strobe falls and R11 outputs hold on an idle cycle
      run_vec(VEC[0], 100);
      held = rsp_pred;
      @(negedge clk);
      check(rsp_valid == 1'b0, "R1 valid drops", PW'(rsp_valid), '0);
      check(rsp_pred == held, "R11 pred held", rsp_pred, held);
      check(rsp_z == 1'b0, "R11 z held", PW'(rsp_z), '0);

      // R2 upper bits ignored: same low halves, different upper halves
      run_vec('{64'hFFFF_0000_0000_0002, 64'h0000_1111_0000_0009, 1'b0, 1'b1, 1'b0, 2'd0}, 200);
      check(rsp_pred == PW'(32'h7F), "R2 upper bits ignored", rsp_pred, PW'(32'h7F));

      // R5 inclusive at top, starting from the bottom of the range
      run_vec('{64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b1, 2'd0}, 201);
      check(rsp_pred == '1, "R5 all bytes active", rsp_pred, '1);

      // R6 signed compare fails where unsigned would pass
      run_vec('{64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b0, 2'd0}, 202);
      check(rsp_z == 1'b1, "R6 signed fail empty", PW'(rsp_z), PW'(1));

      // R3 and R7 back-to-back requests
      @(negedge clk);
      op_a = 64'd0; op_b = 64'd2; wide = 1'b1; is_unsigned = 1'b1; incl = 1'b0;
      esz = 2'd0; req_valid = 1'b1;
      @(negedge clk);
      check(rsp_pred == PW'(32'h3), "R3 first of pair", rsp_pred, PW'(32'h3));
      op_b = 64'd1000;
      @(negedge clk);
      req_valid = 1'b0;
      check(rsp_valid == 1'b1, "R1 second of pair valid", PW'(rsp_valid), PW'(1));
      check(rsp_pred == '1, "R7 second of pair clamp", rsp_pred, '1);

      @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule